// File: doc/BRIEF.md
# Subset Instruction Decoder for a 32-bit Load-Store Core

This block turns one 32-bit instruction word into the control bundle that a downstream datapath consumes. It is purely combinational. The word is cut into its register, immediate and jump-target fields. The primary opcode and, for register-register words, the function code are mapped onto a small operation code. In parallel, the block works out whether a register write happens and to which register, and it forms the extended immediate in the shape the instruction class calls for.

Any encoding outside the supported set raises an illegal flag. An illegal word never produces a register write or a non-zero immediate. A write aimed at register 0 is suppressed, because that register always reads as zero. The register file, ALU, memory and program-counter logic sit outside this block. They only see the decoded bundle.

A parameter selects how the operation code is delivered: as a compact index or as a one-hot vector with one bit per operation.

Top module: `mdec_decoder`

## Requirements
- R1: `rs_addr_o` is always instr[25:21], `rt_addr_o` is instr[20:16], `shamt_o` is instr[10:6] and `jtarget_o` is instr[25:0], whatever the opcode.
- R2: With opcode 0, the function code selects the operation: funct 32 is add (code 1), 34 is sub (code 2), 42 is slt (code 3) and 8 is jr (code 4). In the one-hot variant, bit k alone is set for code k.
- R3: Other opcodes map as follows: addi=8 (code 5), slti=10 (6), ori=13 (7), lui=15 (8), lw=35 (9), sw=43 (10), lb=32 (11), sb=40 (12), beq=4 (13), bne=5 (14), j=2 (15) and jal=3 (16).
- R4: add, sub and slt write the register in instr[15:11].
- R5: addi, slti, ori, lui, lw and lb write the register in instr[20:16].
- R6: jal writes the link register, which is 31.
- R7: sw, sb, beq, bne, j and jr leave `wr_en_o` low.
- R8: A write whose target is register 0 is dropped: `wr_en_o` is low. Whenever `wr_en_o` is low, `wr_addr_o` is 0.
- R9: addi, slti, lw, sw, lb, sb, beq and bne give instr[15:0] sign-extended to 32 bits on `imm_o`.
- R10: ori gives instr[15:0] zero-extended on `imm_o`.
- R11: lui gives instr[15:0] in `imm_o[31:16]`, with `imm_o[15:0]` equal to 0.
- R12: Any opcode/funct pair not listed in R2 and R3 raises `illegal_o` and gives operation code 0, `wr_en_o` low and `imm_o` equal to 0. A listed pair keeps `illegal_o` low.
- R13: add, sub, slt, jr, j and jal give `imm_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | XLEN (32) | Instruction word to decode |
| op_o | output | OPW (5, or 17 if one-hot) | Operation code, as an index or one-hot |
| illegal_o | output | 1 | Encoding not in the supported set |
| rs_addr_o | output | REG_AW (5) | First source register address |
| rt_addr_o | output | REG_AW (5) | Second source register address |
| shamt_o | output | 5 | Shift-amount field |
| jtarget_o | output | 26 | Jump-target field |
| wr_en_o | output | 1 | Register write takes effect |
| wr_addr_o | output | REG_AW (5) | Destination register, 0 when no write |
| imm_o | output | XLEN (32) | Extended immediate |

## Verification
The embedded assertions check a set of relations whenever the inputs settle. These relations are: no write ever reaches register 0, an illegal word writes nothing and carries a zero immediate, the no-write operations keep the write enable low, and the one-hot variant is truly one-hot. They also check the upper half of the immediate for ori and the lower half for lui. The exact opcode and funct map, the choice of rd, rt or the link register, and the sign or zero extension of each class can only be shown by the bench. The bench compares every output against an independent model, over directed corner words and random words.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   localparam int OP_COUNT = 17;
   localparam int OP_IDX_W = 5;

   typedef enum logic [OP_IDX_W-1:0] {
      OPC_ILLEGAL = 5'd0,
      OPC_ADD     = 5'd1,
      OPC_SUB     = 5'd2,
      OPC_SLT     = 5'd3,
      OPC_JR      = 5'd4,
      OPC_ADDI    = 5'd5,
      OPC_SLTI    = 5'd6,
      OPC_ORI     = 5'd7,
      OPC_LUI     = 5'd8,
      OPC_LW      = 5'd9,
      OPC_SW      = 5'd10,
      OPC_LB      = 5'd11,
      OPC_SB      = 5'd12,
      OPC_BEQ     = 5'd13,
      OPC_BNE     = 5'd14,
      OPC_J       = 5'd15,
      OPC_JAL     = 5'd16
   } mdec_op_e;

   typedef enum logic [1:0] {
      IMK_NONE  = 2'd0,
      IMK_SIGN  = 2'd1,
      IMK_ZERO  = 2'd2,
      IMK_UPPER = 2'd3
   } mdec_imm_kind_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RD   = 2'd1,
      DST_RT   = 2'd2,
      DST_LINK = 2'd3
   } mdec_dst_e;

endpackage

// File: rtl/mdec_field_split.sv
module mdec_field_split #(
   parameter int XLEN   = 32,
   parameter int REG_AW = 5
) (
   input  logic [XLEN-1:0]   word_i,
   output logic [5:0]        opcode_o,
   output logic [REG_AW-1:0] rs_o,
   output logic [REG_AW-1:0] rt_o,
   output logic [REG_AW-1:0] rd_o,
   output logic [4:0]        shamt_o,
   output logic [5:0]        funct_o,
   output logic [15:0]       imm16_o,
   output logic [25:0]       target_o
);
   localparam int OP_LSB = XLEN - 6;
   localparam int RS_LSB = OP_LSB - REG_AW;
   localparam int RT_LSB = RS_LSB - REG_AW;
   localparam int RD_LSB = RT_LSB - REG_AW;

   assign opcode_o = word_i[XLEN-1:OP_LSB];
   assign rs_o     = word_i[RS_LSB +: REG_AW];
   assign rt_o     = word_i[RT_LSB +: REG_AW];
   assign rd_o     = word_i[RD_LSB +: REG_AW];
   assign shamt_o  = word_i[10:6];
   assign funct_o  = word_i[5:0];
   assign imm16_o  = word_i[15:0];
   assign target_o = word_i[25:0];
endmodule

// File: rtl/mdec_op_lookup.sv
module mdec_op_lookup
   import mdec_pkg::*;
(
   input  logic [5:0]     opcode_i,
   input  logic [5:0]     funct_i,
   output mdec_op_e       op_o,
   output mdec_dst_e      dst_o,
   output mdec_imm_kind_e imk_o
);
   always_comb begin
      op_o  = OPC_ILLEGAL;
      dst_o = DST_NONE;
      imk_o = IMK_NONE;
      unique case (opcode_i)
         6'd0: begin
            unique case (funct_i)
               6'd32:   begin op_o = OPC_ADD; dst_o = DST_RD; end
               6'd34:   begin op_o = OPC_SUB; dst_o = DST_RD; end
               6'd42:   begin op_o = OPC_SLT; dst_o = DST_RD; end
               6'd8:    op_o = OPC_JR;
               default: op_o = OPC_ILLEGAL;
            endcase
         end
         6'd8:  begin op_o = OPC_ADDI; dst_o = DST_RT; imk_o = IMK_SIGN;  end
         6'd10: begin op_o = OPC_SLTI; dst_o = DST_RT; imk_o = IMK_SIGN;  end
         6'd13: begin op_o = OPC_ORI;  dst_o = DST_RT; imk_o = IMK_ZERO;  end
         6'd15: begin op_o = OPC_LUI;  dst_o = DST_RT; imk_o = IMK_UPPER; end
         6'd35: begin op_o = OPC_LW;   dst_o = DST_RT; imk_o = IMK_SIGN;  end
         6'd32: begin op_o = OPC_LB;   dst_o = DST_RT; imk_o = IMK_SIGN;  end
         6'd43: begin op_o = OPC_SW;   imk_o = IMK_SIGN; end
         6'd40: begin op_o = OPC_SB;   imk_o = IMK_SIGN; end
         6'd4:  begin op_o = OPC_BEQ;  imk_o = IMK_SIGN; end
         6'd5:  begin op_o = OPC_BNE;  imk_o = IMK_SIGN; end
         6'd2:  op_o = OPC_J;
         6'd3:  begin op_o = OPC_JAL;  dst_o = DST_LINK; end
         default: op_o = OPC_ILLEGAL;
      endcase
   end
endmodule

// File: rtl/mdec_ctrl_gen.sv
module mdec_ctrl_gen
   import mdec_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int REG_AW   = 5,
   parameter int LINK_REG = 31
) (
   input  mdec_dst_e         dst_i,
   input  mdec_imm_kind_e    imk_i,
   input  logic [REG_AW-1:0] rt_i,
   input  logic [REG_AW-1:0] rd_i,
   input  logic [15:0]       imm16_i,
   output logic              wr_en_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [XLEN-1:0]   imm_o
);
   localparam int EXT_W = XLEN - 16;
   localparam logic [REG_AW-1:0] LINK_A = REG_AW'(LINK_REG);

   logic [REG_AW-1:0] target_reg;

   always_comb begin
      unique case (dst_i)
         DST_RD:   target_reg = rd_i;
         DST_RT:   target_reg = rt_i;
         DST_LINK: target_reg = LINK_A;
         default:  target_reg = '0;
      endcase
      wr_en_o   = (dst_i != DST_NONE) && (target_reg != '0);
      wr_addr_o = wr_en_o ? target_reg : '0;
   end

   always_comb begin
      unique case (imk_i)
         IMK_SIGN:  imm_o = {{EXT_W{imm16_i[15]}}, imm16_i};
         IMK_ZERO:  imm_o = {{EXT_W{1'b0}}, imm16_i};
         IMK_UPPER: imm_o = {imm16_i, {EXT_W{1'b0}}};
         default:   imm_o = '0;
      endcase
   end

   always_comb begin
      a_r8_no_zero_write: assert (!(wr_en_o && wr_addr_o == '0))
         else $error("write enabled toward register 0");
      if (dst_i == DST_NONE) begin
         a_r7_no_dst_no_write: assert (!wr_en_o && wr_addr_o == '0)
            else $error("write without destination class");
      end
   end
endmodule

// File: rtl/mdec_decoder.sv
module mdec_decoder
   import mdec_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int REG_AW    = 5,
   parameter int LINK_REG  = 31,
   parameter bit ONEHOT_OP = 1'b0,
   localparam int OPW      = ONEHOT_OP ? OP_COUNT : OP_IDX_W
) (
   input  logic [XLEN-1:0]   instr_i,
   output logic [OPW-1:0]    op_o,
   output logic              illegal_o,
   output logic [REG_AW-1:0] rs_addr_o,
   output logic [REG_AW-1:0] rt_addr_o,
   output logic [4:0]        shamt_o,
   output logic [25:0]       jtarget_o,
   output logic              wr_en_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [XLEN-1:0]   imm_o
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("instruction formats need XLEN of 32");
      end
      if (REG_AW != 5) begin : g_bad_aw
         $error("register fields are 5 bits wide");
      end
      if (LINK_REG <= 0 || LINK_REG >= (1 << REG_AW)) begin : g_bad_link
         $error("link register must be a writable register");
      end
   endgenerate

   logic [5:0]        opcode, funct;
   logic [REG_AW-1:0] rd_f;
   logic [15:0]       imm16;
   mdec_op_e          op_idx;
   mdec_dst_e         dst;
   mdec_imm_kind_e    imk;

   mdec_field_split #(.XLEN(XLEN), .REG_AW(REG_AW)) u_split (
      .word_i   (instr_i),
      .opcode_o (opcode),
      .rs_o     (rs_addr_o),
      .rt_o     (rt_addr_o),
      .rd_o     (rd_f),
      .shamt_o  (shamt_o),
      .funct_o  (funct),
      .imm16_o  (imm16),
      .target_o (jtarget_o)
   );

   mdec_op_lookup u_lookup (
      .opcode_i (opcode),
      .funct_i  (funct),
      .op_o     (op_idx),
      .dst_o    (dst),
      .imk_o    (imk)
   );

   mdec_ctrl_gen #(.XLEN(XLEN), .REG_AW(REG_AW), .LINK_REG(LINK_REG)) u_ctrl (
      .dst_i     (dst),
      .imk_i     (imk),
      .rt_i      (rt_addr_o),
      .rd_i      (rd_f),
      .imm16_i   (imm16),
      .wr_en_o   (wr_en_o),
      .wr_addr_o (wr_addr_o),
      .imm_o     (imm_o)
   );

   assign illegal_o = (op_idx == OPC_ILLEGAL);

   generate
      if (ONEHOT_OP) begin : g_onehot
         assign op_o = OPW'(1) << op_idx;
         always_comb begin
            a_r2_onehot_code: assert ($onehot(op_o))
               else $error("operation code not one-hot");
         end
      end else begin : g_index
         assign op_o = OPW'(op_idx);
      end
   endgenerate

   always_comb begin
      if (illegal_o) begin
         a_r12_illegal_quiet: assert (!wr_en_o && imm_o == '0)
            else $error("illegal word produced a write or immediate");
      end
      if (op_idx inside {OPC_SW, OPC_SB, OPC_BEQ, OPC_BNE, OPC_J, OPC_JR}) begin
         a_r7_store_branch_no_write: assert (!wr_en_o)
            else $error("no-write operation enabled a write");
      end
      if (op_idx == OPC_ORI) begin
         a_r10_ori_upper_clear: assert (imm_o[XLEN-1:16] == '0)
            else $error("ori immediate upper half not zero");
      end
      if (op_idx == OPC_LUI) begin
         a_r11_lui_lower_clear: assert (imm_o[15:0] == '0)
            else $error("lui immediate lower half not zero");
      end
   end
endmodule

// File: tb/mdec_decoder_tb_top.sv
module mdec_decoder_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] instr;
   logic [4:0]  op;
   logic        ill, we;
   logic [4:0]  rs, rt, wa, sh;
   logic [25:0] jt;
   logic [31:0] imm;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   mdec_decoder dut_i (
      .instr_i   (instr),
      .op_o      (op),
      .illegal_o (ill),
      .rs_addr_o (rs),
      .rt_addr_o (rt),
      .shamt_o   (sh),
      .jtarget_o (jt),
      .wr_en_o   (we),
      .wr_addr_o (wa),
      .imm_o     (imm)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s instr=%08h actual=%0h expected=%0h",
                  req, what, instr, act, exp);
      end
   endtask

   // independent model: code, destination class (0 none,1 rd,2 rt,3 link),
   // immediate class (0 none,1 sign,2 zero,3 upper)
   task automatic model(input logic [31:0] w, output int code,
                        output int dcls, output int icls);
      logic [5:0] o, f;
      o = w[31:26]; f = w[5:0];
      code = 0; dcls = 0; icls = 0;
      if (o == 0) begin
         if (f == 32) begin code = 1; dcls = 1; end
         else if (f == 34) begin code = 2; dcls = 1; end
         else if (f == 42) begin code = 3; dcls = 1; end
         else if (f == 8) code = 4;
      end
      else if (o == 8)  begin code = 5;  dcls = 2; icls = 1; end
      else if (o == 10) begin code = 6;  dcls = 2; icls = 1; end
      else if (o == 13) begin code = 7;  dcls = 2; icls = 2; end
      else if (o == 15) begin code = 8;  dcls = 2; icls = 3; end
      else if (o == 35) begin code = 9;  dcls = 2; icls = 1; end
      else if (o == 43) begin code = 10; icls = 1; end
      else if (o == 32) begin code = 11; dcls = 2; icls = 1; end
      else if (o == 40) begin code = 12; icls = 1; end
      else if (o == 4)  begin code = 13; icls = 1; end
      else if (o == 5)  begin code = 14; icls = 1; end
      else if (o == 2)  code = 15;
      else if (o == 3)  begin code = 16; dcls = 3; end
   endtask

   task automatic apply(input logic [31:0] w);
      int code, dcls, icls;
      logic [4:0]  tgt, ewa;
      logic        ewe;
      logic [31:0] eimm;
      string rq_op, rq_wr, rq_im;
      @(posedge clk);
      instr = w;
      @(negedge clk);
      model(w, code, dcls, icls);
      case (dcls)
         1: tgt = w[15:11];
         2: tgt = w[20:16];
         3: tgt = 5'd31;
         default: tgt = 5'd0;
      endcase
      ewe = (dcls != 0) && (tgt != 0);
      ewa = ewe ? tgt : 5'd0;
      case (icls)
         1: eimm = {{16{w[15]}}, w[15:0]};
         2: eimm = {16'h0, w[15:0]};
         3: eimm = {w[15:0], 16'h0};
         default: eimm = 32'h0;
      endcase
      rq_op = (code == 0) ? "R12" : (code <= 4) ? "R2" : "R3";
      if (code == 0) rq_wr = "R12";
      else if (dcls != 0 && tgt == 0) rq_wr = "R8";
      else if (dcls == 1) rq_wr = "R4";
      else if (dcls == 2) rq_wr = "R5";
      else if (dcls == 3) rq_wr = "R6";
      else rq_wr = "R7";
      case (icls)
         1: rq_im = "R9";
         2: rq_im = "R10";
         3: rq_im = "R11";
         default: rq_im = (code == 0) ? "R12" : "R13";
      endcase
      chk(rq_op, "op", 32'(op), 32'(code));
      chk(rq_op, "illegal", 32'(ill), 32'(code == 0));
      chk(rq_wr, "wr_en", 32'(we), 32'(ewe));
      chk(rq_wr, "wr_addr", 32'(wa), 32'(ewa));
      chk(rq_im, "imm", imm, eimm);
      chk("R1", "fields", {rs, rt, sh, 1'b0, 16'h0}, {w[25:21], w[20:16], w[10:6], 1'b0, 16'h0});
      chk("R1", "target", 32'(jt), 32'(w[25:0]));
   endtask

   function automatic logic [31:0] mk(input int o, input int rsv, input int rtv,
                                      input int rdv, input int f, input logic [15:0] im);
      logic [31:0] w;
      w = {o[5:0], rsv[4:0], rtv[4:0], im};
      if (o == 0) w[15:0] = {rdv[4:0], 5'd3, f[5:0]};
      return w;
   endfunction

   initial begin
      int opc [12] = '{8, 10, 13, 15, 35, 43, 32, 40, 4, 5, 2, 3};
      int fnc [4]  = '{32, 34, 42, 8};
      void'($urandom(32'd1234));
      instr = 32'h0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle word: opcode 0 funct 0 is unsupported (R12)
      apply(32'h0000_0000);
      // directed R2/R4 register-register
      apply(mk(0, 9, 10, 8, 32, 0));
      apply(mk(0, 1, 2, 3, 34, 0));
      apply(mk(0, 4, 5, 6, 42, 0));
      apply(mk(0, 31, 0, 0, 8, 0));
      // R8 add to register 0
      apply(mk(0, 9, 10, 0, 32, 0));
      // R5/R9 negative and positive offsets
      apply(mk(8, 29, 29, 0, 0, 16'hFFFC));
      apply(mk(35, 2, 1, 0, 0, 16'h0020));
      apply(mk(32, 3, 7, 0, 0, 16'h8000));
      // R8 load into register 0
      apply(mk(35, 2, 0, 0, 0, 16'h0004));
      // R10 ori with bit 15 set stays zero-extended
      apply(mk(13, 8, 8, 0, 0, 16'hAAAA));
      // R11 lui
      apply(mk(15, 0, 8, 0, 0, 16'hAAAA));
      // R7 stores/branches/jump
      apply(mk(43, 5, 6, 0, 0, 16'hFFF0));
      apply(mk(40, 5, 6, 0, 0, 16'h0006));
      apply(mk(4, 1, 2, 0, 0, 16'd25));
      apply(mk(5, 1, 2, 0, 0, 16'hFFFF));
      apply(32'h0800_09C4);
      // R6 jal
      apply(32'h0C00_09C4);
      // R12 unlisted opcode and funct
      apply(mk(1, 1, 2, 0, 0, 16'h1234));
      apply(mk(0, 1, 2, 3, 33, 0));
      apply(32'hFFFF_FFFF);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int sel;
         logic [31:0] w;
         sel = $urandom_range(0, 9);
         w = $urandom;
         if (sel < 7) begin
            w[31:26] = (sel < 2) ? 6'd0 : 6'(opc[$urandom_range(0, 11)]);
            if (sel < 2) w[5:0] = 6'(fnc[$urandom_range(0, 3)]);
            if ($urandom_range(0, 7) == 0) w[20:16] = 5'd0;
            if ($urandom_range(0, 7) == 0) w[15:11] = 5'd0;
         end
         apply(w);
      end
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired before stimulus completed");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule